// File: doc/BRIEF.md
# Edge/Level Interrupt Trigger Conditioner

This block sits in front of an interrupt controller and turns sixteen raw interrupt request lines into clean request signals. For each line, a mode bit held in one of two byte-wide I/O registers selects how the raw input is read. In edge mode, a low-to-high transition is captured as a sticky pending request that stays up until the line is acknowledged. In level mode, the request simply follows the input while it is high.

Each raw input first passes through a two-flop synchronizer. Edge detection and level pass-through both act on the synchronized copy. Five lines (0, 1, 2, 8 and 13) are hard-wired to edge mode. Their mode bits, and the unused bit positions, always read back as zero.

The mode registers sit at two consecutive I/O addresses. The low address holds the bank for lines 7..0 and the next address holds the bank for lines 15..8. A write takes effect on the clock edge where the write strobe is sampled. A read returns its data on `io_rdata` from the clock edge where the read strobe is sampled, and that value holds until the next read.

Top module: `irq_trigger_cond`

## Requirements
- R1: After reset, every mode bit is 0 (all lines edge mode), `req_out` is 0 and `io_rdata` is 0x00.
- R2: The register at address 0x4D0 holds the mode of lines 3..7, with bit n selecting line n. A 1 selects level mode and a 0 selects edge mode. Its programmable bits read back as last written.
- R3: The register at address 0x4D1 holds the mode of lines 9, 10, 11, 12, 14 and 15 in bits 1, 2, 3, 4, 6 and 7, with bit b selecting line 8+b. A 1 selects level mode. These bits read back as last written.
- R4: Bits 2:0 of 0x4D0 and bits 0 and 5 of 0x4D1 ignore writes and read as 0. Lines 0, 1, 2, 8 and 13 therefore always behave as edge lines.
- R5: On an edge-mode line, consider a rising input first sampled at clock edge k. It raises `req_out` for that line after edge k+2, and the request stays high after the input falls.
- R6: On an edge-mode line, asserting `irq_ack` for one cycle clears the pending request at the next clock edge. Nothing else clears it while the line stays in edge mode.
- R7: On a level-mode line, `req_out` equals the input sampled two clock edges earlier. `irq_ack` has no effect on it.
- R8: Switching a line from edge to level mode discards its pending request. A line switched back to edge mode while its input is steadily high raises no request.
- R9: A read of any address other than 0x4D0 or 0x4D1 returns 0x00. A write to such an address changes no mode bit.
- R10: `io_rdata` changes only on a clock edge where `io_rd` is sampled high.
- R11: If a new rising edge is detected in the same cycle as `irq_ack` for that line, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| irq_in | input | 16 | Raw interrupt request lines |
| irq_ack | input | 16 | Per-line acknowledge for pending edge requests |
| req_out | output | 16 | Conditioned requests to the interrupt controller |

## Verification
The bench builds the block with its default parameters: sixteen lines, base address 0x4D0 and a two-stage synchronizer. At that size, all 256 data values can be written to and read back from both registers, and every one of the sixteen lines can be driven through rise, fall and acknowledge in both modes. The expected request vectors come from the bench's own list of fixed-edge lines and the two-edge synchronizer latency. This exposes any crossed bit, wrong reserved mask or off-by-one cycle. Mode switching with a pending request, and an acknowledge that coincides with a new edge, are checked as separate targeted sequences.

// File: rtl/irqtc_pkg.sv
package irqtc_pkg;
    // Width of one mode register and total line count.
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned LINES   = 16;
    localparam int unsigned BANKS   = LINES / DATA_W;

    // Register-file state: mode bits plus the latched read data.
    typedef struct packed {
        logic [LINES-1:0]  mode;
        logic [DATA_W-1:0] rdata;
    } regs_state_t;

    // Per-line conditioning state.
    typedef struct packed {
        logic prev;
        logic pending;
    } line_state_t;
endpackage

// File: rtl/irqtc_sync.sv
module irqtc_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqtc_regs.sv
module irqtc_regs
    import irqtc_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h04D0,
    parameter logic [LINES-1:0]  PROG_MASK = 16'hDEF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic [LINES-1:0]  mode_vec
);
    regs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < int'(BANKS); b++) begin
            // A read sees the value held before any same-cycle write.
            if (io_rd && io_addr == BASE_ADDR + ADDR_W'(b)) begin
                st_d.rdata = st_q.mode[b*DATA_W +: DATA_W];
            end
            if (io_wr && io_addr == BASE_ADDR + ADDR_W'(b)) begin
                st_d.mode[b*DATA_W +: DATA_W] =
                    io_wdata & PROG_MASK[b*DATA_W +: DATA_W];
            end
        end
        if (io_rd && (io_addr < BASE_ADDR ||
                      io_addr >= BASE_ADDR + ADDR_W'(BANKS))) begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = st_q.rdata;
    assign mode_vec = st_q.mode;
endmodule

// File: rtl/irqtc_line.sv
module irqtc_line
    import irqtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic level_mode,
    input  logic ack,
    output logic req
);
    line_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d      = st_q;
        rise      = sync_in & ~st_q.prev;
        st_d.prev = sync_in;
        if (level_mode) begin
            st_d.pending = 1'b0;        // stale edge dropped on switch
        end else if (rise) begin
            st_d.pending = 1'b1;        // new edge beats acknowledge
        end else if (ack) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = level_mode ? sync_in : st_q.pending;
endmodule

// File: rtl/irq_trigger_cond.sv
module irq_trigger_cond
    import irqtc_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h04D0,
    parameter logic [LINES-1:0]  PROG_MASK   = 16'hDEF8,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [LINES-1:0]  irq_in,
    input  logic [LINES-1:0]  irq_ack,
    output logic [LINES-1:0]  req_out
);
    logic [LINES-1:0] mode_vec;
    logic [LINES-1:0] irq_sync;

    irqtc_regs #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .PROG_MASK(PROG_MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_rdata(io_rdata),
        .mode_vec(mode_vec)
    );

    irqtc_sync #(
        .WIDTH (LINES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (irq_sync)
    );

    generate
        for (genvar i = 0; i < int'(LINES); i++) begin : g_line
            irqtc_line u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .sync_in   (irq_sync[i]),
                .level_mode(mode_vec[i]),
                .ack       (irq_ack[i]),
                .req       (req_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/irqtc_checker.sv
module irqtc_checker
    import irqtc_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h04D0,
    parameter logic [LINES-1:0]  PROG_MASK = 16'hDEF8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_rdata,
    input logic [LINES-1:0]  irq_in,
    input logic [LINES-1:0]  irq_ack,
    input logic [LINES-1:0]  req_out,
    input logic [LINES-1:0]  mode_vec
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_reserved_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == BASE_ADDR) |=> ((io_rdata & ~PROG_MASK[DATA_W-1:0]) == '0));

    assert_reserved_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == BASE_ADDR + ADDR_W'(1)) |=>
            ((io_rdata & ~PROG_MASK[LINES-1:DATA_W]) == '0));

    assert_other_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != BASE_ADDR && io_addr != BASE_ADDR + ADDR_W'(1))
            |=> (io_rdata == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> ((req_out & mode_vec) == ($past(irq_in, 2) & mode_vec)));

    assert_pending_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) |->
            ((($past(req_out) & ~$past(mode_vec) & ~$past(irq_ack)) & ~mode_vec & ~req_out) == '0));
endmodule

bind irq_trigger_cond irqtc_checker #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .PROG_MASK(PROG_MASK)
) u_irqtc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_rdata(io_rdata),
    .irq_in  (irq_in),
    .irq_ack (irq_ack),
    .req_out (req_out),
    .mode_vec(mode_vec)
);

// File: tb/test_irq_trigger_cond.sv
module test_irq_trigger_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [15:0] irq_in = '0;
    logic [15:0] irq_ack = '0;
    logic [15:0] req_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    irq_trigger_cond i_irq_trigger_cond (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .irq_in(irq_in), .irq_ack(irq_ack), .req_out(req_out)
    );

    function automatic bit is_prog(int line);
        return !(line == 0 || line == 1 || line == 2 || line == 8 || line == 13);
    endfunction

    function automatic logic [15:0] prog_mask();
        logic [15:0] m = '0;
        for (int i = 0; i < 16; i++) m[i] = is_prog(i);
        return m;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic io_read(logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        tick();
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic [15:0] pm;
        pm = prog_mask();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 req", req_out, 16'h0);
        check("R1 rdata", {8'h0, io_rdata}, 16'h0);
        io_read(16'h04D0, rd); check("R1 low reg", {8'h0, rd}, 16'h0);
        io_read(16'h04D1, rd); check("R1 high reg", {8'h0, rd}, 16'h0);

        // R2 R3 R4: sweep every data value through both registers
        for (int v = 0; v < 256; v++) begin
            io_write(16'h04D0, 8'(v));
            io_read(16'h04D0, rd);
            check("R2/R4 low readback", {8'h0, rd}, {8'h0, 8'(v) & pm[7:0]});
            io_write(16'h04D1, 8'(v));
            io_read(16'h04D1, rd);
            check("R3/R4 high readback", {8'h0, rd}, {8'h0, 8'(v) & pm[15:8]});
        end

        // R9 R10: stray addresses
        io_write(16'h04D0, 8'hA8);
        io_write(16'h04D1, 8'h52);
        io_write(16'h04D2, 8'hFF);
        io_write(16'h04CF, 8'hFF);
        io_write(16'h00D0, 8'h00);
        io_read(16'h04D0, rd); check("R9 low unchanged", {8'h0, rd}, 16'h00A8);
        repeat (3) tick();
        check("R10 rdata held", {8'h0, io_rdata}, 16'h00A8);
        io_read(16'h04D1, rd); check("R9 high unchanged", {8'h0, rd}, 16'h0052);
        io_read(16'h04D2, rd); check("R9 stray read", {8'h0, rd}, 16'h0);
        io_read(16'h14D0, rd); check("R9 stray read 2", {8'h0, rd}, 16'h0);

        // R5 R6 R7: every line, all-level request then all-edge request
        for (int pass = 0; pass < 2; pass++) begin
            io_write(16'h04D0, pass == 0 ? 8'hFF : 8'h00);
            io_write(16'h04D1, pass == 0 ? 8'hFF : 8'h00);
            for (int i = 0; i < 16; i++) begin
                logic [15:0] bitv;
                bit lvl;
                bitv = 16'(1) << i;
                lvl  = (pass == 0) && is_prog(i);
                irq_in = bitv;
                tick(); check("R5/R7 after one edge", req_out, 16'h0);
                tick(); check(lvl ? "R7 level rise" : "R5 not yet", req_out, lvl ? bitv : 16'h0);
                tick(); check("R5/R7 request up", req_out, bitv);
                irq_in = '0;
                tick(); tick();
                check(lvl ? "R7 level fall" : "R5 sticky", req_out, lvl ? 16'h0 : bitv);
                if (!lvl) begin
                    irq_ack = bitv; tick(); irq_ack = '0;
                    check("R6 ack clears", req_out, 16'h0);
                    tick(); check("R6 stays clear", req_out, 16'h0);
                end else begin
                    irq_in = bitv; tick(); tick();
                    irq_ack = bitv; tick(); irq_ack = '0;
                    check("R7 ack ignored", req_out, bitv);
                    irq_in = '0; tick(); tick();
                    check("R7 level low", req_out, 16'h0);
                end
            end
        end

        // R8: pending edge on line 3 dropped by a switch to level mode
        io_write(16'h04D0, 8'h00);
        irq_in = 16'h0008; tick(); tick(); tick();
        irq_in = '0; tick(); tick();
        check("R8 pending before switch", req_out, 16'h0008);
        io_write(16'h04D0, 8'h08);
        check("R8 level shows low input", req_out, 16'h0);
        io_write(16'h04D0, 8'h00);
        tick(); check("R8 stale request gone", req_out, 16'h0);
        io_write(16'h04D0, 8'h08);
        irq_in = 16'h0008; tick(); tick();
        check("R8 level high", req_out, 16'h0008);
        io_write(16'h04D0, 8'h00);
        tick(); tick(); check("R8 steady high no edge", req_out, 16'h0);
        irq_in = '0; tick(); tick();

        // R11: acknowledge coinciding with detection of a new edge (line 9)
        irq_in = 16'h0200; tick(); tick();
        irq_ack = 16'h0200; tick(); irq_ack = '0;
        check("R11 edge beats ack", req_out, 16'h0200);
        irq_ack = 16'h0200; tick(); irq_ack = '0;
        check("R6 later ack clears", req_out, 16'h0);
        irq_in = '0; tick(); tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule